// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits between a bus front end and a slave memory and decides whether exclusive read/write pairs succeed. Each accepted request carries a direction, an exclusive flag, a transaction ID, a byte address and a transfer size. The block answers with a response code and with a flag that tells the memory whether the write may be committed. The memory array, the burst logic and the full bus channels sit outside the block. A single valid/ready request port and a single valid/ready response port connect it to the rest of the slave.

The monitor holds one reservation slot for every possible ID value. Each slot stores a valid bit, the aligned granule address and the transfer size. An exclusive read fills the slot of its ID. An exclusive write succeeds only when its own slot still holds the same granule and size. Any write that reaches memory, whether exclusive or ordinary, removes every reservation on that granule, whichever ID owns it. A later exclusive write to the same place from another ID therefore fails and is suppressed. A build parameter can switch exclusive support off. Exclusive reads then answer OKAY, and the requester must treat that as failure of the exclusive operation.

Top module: `exmon_top`

## Requirements
- R1: With support enabled, an accepted exclusive read responds with EXOKAY (code 2'b01), does not set the commit flag, and reserves its granule and size in the slot of its ID.
- R2: There are 2**ID_W independent slots, one per ID, and every ID can hold a reservation at the same time. A new exclusive read from an ID replaces that ID's earlier reservation.
- R3: An exclusive write whose ID slot is valid and holds the same granule and size responds with EXOKAY and sets the commit flag.
- R4: A committed write, exclusive or ordinary, invalidates every slot whose granule equals the write's granule, for all IDs, including the writer's own slot.
- R5: An exclusive write without a matching reservation responds with OKAY (code 2'b00), clears the commit flag and leaves every slot unchanged.
- R6: Addresses are compared per granule of 2**GRAN_LOG2 bytes, so addresses inside one granule match. A different granule, or a different size field, counts as no match.
- R7: An ordinary read responds with OKAY, clears the commit flag and leaves every slot unchanged.
- R8: An ordinary write always responds with OKAY and sets the commit flag.
- R9: With support disabled (EXCL_SUPPORT=0), exclusive reads respond with OKAY and exclusive writes respond with OKAY without commit, while ordinary writes still commit.
- R10: req_ready equals !resp_valid || resp_ready. A response appears in the cycle after acceptance and holds its code and commit flag stable while resp_valid is high and resp_ready is low.
- R11: Reset clears resp_valid and invalidates every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | Exclusive access |
| req_id | input | ID_W | Transaction ID |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Transfer size code |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken |
| resp_code | output | 2 | 2'b00 OKAY, 2'b01 EXOKAY |
| resp_wr_ok | output | 1 | Write may be committed to memory |

## Verification
The bench builds the main instance with ID_W=3, ADDR_W=16 and GRAN_LOG2=3. With these values all eight slots can be filled and then drained one by one, and the full set of IDs can be swept in a single test. Neighbouring byte addresses that share an 8-byte granule, and addresses that fall just across a granule edge, are easy to reach. A second instance with the same sizes and EXCL_SUPPORT=0 receives the same stimulus, so the bench can compare the unsupported answers directly against the supported ones.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

    localparam int SIZE_W = 3;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01
    } resp_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } tbl_act_e;

endpackage

// File: rtl/exmon_match.sv
module exmon_match
    import exmon_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int GW    = 29,
    localparam int DEPTH = 1 << ID_W
) (
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0][GW-1:0]     ent_gran,
    input  logic [DEPTH-1:0][SIZE_W-1:0] ent_size,
    input  logic [ID_W-1:0]              req_id,
    input  logic [GW-1:0]                req_gran,
    input  logic [SIZE_W-1:0]            req_size,
    output logic [DEPTH-1:0]             gran_hit,
    output logic                         own_hit
);

    // one comparator per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign gran_hit[i] = ent_vld[i] && (ent_gran[i] == req_gran);
    end

    // the requester's own slot must also agree on size
    always_comb begin
        own_hit = gran_hit[req_id] && (ent_size[req_id] == req_size);
    end

endmodule

// File: rtl/exmon_ctrl.sv
module exmon_ctrl
    import exmon_pkg::*;
#(
    parameter bit EXCL_SUPPORT = 1'b1
) (
    input  logic     fire,
    input  logic     is_write,
    input  logic     is_excl,
    input  logic     own_hit,
    output tbl_act_e act,
    output resp_e    code,
    output logic     commit
);

    always_comb begin
        act    = ACT_NONE;
        code   = RESP_OKAY;
        commit = 1'b0;
        if (!is_write) begin
            if (is_excl && EXCL_SUPPORT) begin
                act  = ACT_SET;
                code = RESP_EXOKAY;
            end
        end else if (is_excl) begin
            if (own_hit && EXCL_SUPPORT) begin
                act    = ACT_CLR;
                code   = RESP_EXOKAY;
                commit = 1'b1;
            end
        end else begin
            act    = ACT_CLR;
            commit = 1'b1;
        end
        if (!fire) begin
            act = ACT_NONE;
        end
    end

endmodule

// File: rtl/exmon_table.sv
module exmon_table
    import exmon_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int GW    = 29,
    localparam int DEPTH = 1 << ID_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  tbl_act_e                     act,
    input  logic [ID_W-1:0]              req_id,
    input  logic [GW-1:0]                req_gran,
    input  logic [SIZE_W-1:0]            req_size,
    input  logic [DEPTH-1:0]             gran_hit,
    output logic [DEPTH-1:0]             ent_vld,
    output logic [DEPTH-1:0][GW-1:0]     ent_gran,
    output logic [DEPTH-1:0][SIZE_W-1:0] ent_size
);

    typedef struct packed {
        logic              vld;
        logic [GW-1:0]     gran;
        logic [SIZE_W-1:0] size;
    } slot_t;

    slot_t [DEPTH-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < DEPTH; i++) begin
            unique case (act)
                ACT_SET: begin
                    if (req_id == ID_W'(i)) begin
                        tbl_d[i].vld  = 1'b1;
                        tbl_d[i].gran = req_gran;
                        tbl_d[i].size = req_size;
                    end
                end
                ACT_CLR: begin
                    if (gran_hit[i]) begin
                        tbl_d[i].vld = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign ent_vld[i]  = tbl_q[i].vld;
        assign ent_gran[i] = tbl_q[i].gran;
        assign ent_size[i] = tbl_q[i].size;
    end

endmodule

// File: rtl/exmon_top.sv
module exmon_top
    import exmon_pkg::*;
#(
    parameter int ID_W         = 4,
    parameter int ADDR_W       = 32,
    parameter int GRAN_LOG2    = 3,
    parameter bit EXCL_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_excl,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [1:0]        resp_code,
    output logic              resp_wr_ok
);

    localparam int DEPTH = 1 << ID_W;
    localparam int GW    = ADDR_W - GRAN_LOG2;

    typedef struct packed {
        logic  valid;
        resp_e code;
        logic  commit;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic                         fire;
    logic [GW-1:0]                req_gran;
    logic [DEPTH-1:0]             ent_vld;
    logic [DEPTH-1:0][GW-1:0]     ent_gran;
    logic [DEPTH-1:0][SIZE_W-1:0] ent_size;
    logic [DEPTH-1:0]             gran_hit;
    logic                         own_hit;
    tbl_act_e                     act;
    resp_e                        code;
    logic                         commit;

    assign req_ready = !rsp_q.valid || resp_ready;
    assign fire      = req_valid && req_ready;
    assign req_gran  = req_addr[ADDR_W-1:GRAN_LOG2];

    exmon_match #(.ID_W(ID_W), .GW(GW)) u_match (
        .ent_vld  (ent_vld),
        .ent_gran (ent_gran),
        .ent_size (ent_size),
        .req_id   (req_id),
        .req_gran (req_gran),
        .req_size (req_size),
        .gran_hit (gran_hit),
        .own_hit  (own_hit)
    );

    exmon_ctrl #(.EXCL_SUPPORT(EXCL_SUPPORT)) u_ctrl (
        .fire     (fire),
        .is_write (req_write),
        .is_excl  (req_excl),
        .own_hit  (own_hit),
        .act      (act),
        .code     (code),
        .commit   (commit)
    );

    exmon_table #(.ID_W(ID_W), .GW(GW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .req_id   (req_id),
        .req_gran (req_gran),
        .req_size (req_size),
        .gran_hit (gran_hit),
        .ent_vld  (ent_vld),
        .ent_gran (ent_gran),
        .ent_size (ent_size)
    );

    always_comb begin
        rsp_d = rsp_q;
        if (fire) begin
            rsp_d.valid  = 1'b1;
            rsp_d.code   = code;
            rsp_d.commit = commit;
        end else if (resp_ready) begin
            rsp_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, code: RESP_OKAY, commit: 1'b0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign resp_valid = rsp_q.valid;
    assign resp_code  = rsp_q.code;
    assign resp_wr_ok = rsp_q.commit;

endmodule

// File: rtl/exmon_chk.sv
module exmon_chk #(
    parameter bit EXCL_SUPPORT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic       req_excl,
    input logic       resp_valid,
    input logic       resp_ready,
    input logic [1:0] resp_code,
    input logic       resp_wr_ok
);

    logic acc;
    assign acc = req_valid && req_ready;

    assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> resp_valid);

    assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_code) && $stable(resp_wr_ok)));

    assert_read_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write) |=> !resp_wr_ok);

    assert_plain_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && !req_excl) |=> (resp_wr_ok && resp_code == 2'b00));

    assert_excl_write_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && req_excl) |=> (resp_wr_ok == (resp_code == 2'b01)));

    assert_excl_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_excl && EXCL_SUPPORT) |=> (resp_code == 2'b01));

    assert_no_support_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_excl && !EXCL_SUPPORT) |=> (resp_code == 2'b00));

    assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code inside {2'b00, 2'b01}));

endmodule

bind exmon_top exmon_chk #(.EXCL_SUPPORT(EXCL_SUPPORT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_excl   (req_excl),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_code  (resp_code),
    .resp_wr_ok (resp_wr_ok)
);

// File: tb/exmon_top_tb.sv
module exmon_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 3;
    localparam int AW   = 16;
    localparam logic [1:0] OK  = 2'b00;
    localparam logic [1:0] EXO = 2'b01;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_excl = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = 3'd2;
    logic          resp_ready = 1'b1;
    logic          req_ready, resp_valid, resp_wr_ok;
    logic [1:0]    resp_code;
    logic          nx_req_ready, nx_resp_valid, nx_resp_wr_ok;
    logic [1:0]    nx_resp_code;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exmon_top #(.ID_W(ID_W), .ADDR_W(AW), .GRAN_LOG2(3), .EXCL_SUPPORT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr),
        .req_size(req_size), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_code(resp_code), .resp_wr_ok(resp_wr_ok)
    );

    exmon_top #(.ID_W(ID_W), .ADDR_W(AW), .GRAN_LOG2(3), .EXCL_SUPPORT(1'b0)) u_nx (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(nx_req_ready),
        .req_write(req_write), .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr),
        .req_size(req_size), .resp_valid(nx_resp_valid), .resp_ready(resp_ready),
        .resp_code(nx_resp_code), .resp_wr_ok(nx_resp_wr_ok)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // at a negedge: present one request, return at the negedge after acceptance
    task automatic xfer(input logic w, input logic x, input int id, input int addr, input int sz);
        req_valid = 1'b1;
        req_write = w;
        req_excl  = x;
        req_id    = ID_W'(id);
        req_addr  = AW'(addr);
        req_size  = 3'(sz);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic [1:0] code, input logic wr);
        check(tag, {resp_valid, resp_code}, {1'b1, code});
        check({tag, " commit"}, {2'b0, resp_wr_ok}, {2'b0, wr});
    endtask

    task automatic idle();
        req_valid = 1'b0;
        resp_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 resp_valid after reset", {2'b0, resp_valid}, 3'b000);
        check("R11/R10 ready after reset", {2'b0, req_ready}, 3'b001);
        xfer(1, 1, 3, 'h0000, 2);
        expect_rsp("R11 empty table excl write", OK, 0);
    endtask

    task automatic t_both_pass();
        xfer(0, 1, 0, 'hA000, 2); expect_rsp("R1 excl read id0", EXO, 0);
        xfer(0, 1, 1, 'hB000, 2); expect_rsp("R1 excl read id1", EXO, 0);
        xfer(1, 1, 0, 'hA000, 2); expect_rsp("R3 excl write id0", EXO, 1);
        xfer(1, 1, 1, 'hB000, 2); expect_rsp("R3 excl write id1", EXO, 1);
        xfer(1, 1, 0, 'hA000, 2); expect_rsp("R4 own slot cleared", OK, 0);
    endtask

    task automatic t_one_fails();
        xfer(0, 1, 0, 'hA000, 2); expect_rsp("R1 read id0 A000", EXO, 0);
        xfer(0, 1, 1, 'hA000, 2); expect_rsp("R1 read id1 A000", EXO, 0);
        xfer(1, 1, 0, 'hA000, 2); expect_rsp("R3 write id0 A000", EXO, 1);
        xfer(1, 1, 1, 'hA000, 2); expect_rsp("R4 other id invalidated", OK, 0);
    endtask

    task automatic t_plain_write_breaks();
        xfer(0, 1, 2, 'h0100, 2); expect_rsp("R1 read id2", EXO, 0);
        xfer(1, 0, 5, 'h0104, 2); expect_rsp("R8 plain write", OK, 1);
        xfer(1, 1, 2, 'h0100, 2); expect_rsp("R4 plain write same granule clears", OK, 0);
        xfer(0, 1, 2, 'h0100, 2);
        xfer(1, 0, 5, 'h0108, 2); expect_rsp("R8 plain write next granule", OK, 1);
        xfer(1, 1, 2, 'h0100, 2); expect_rsp("R6 other granule leaves slot", EXO, 1);
    endtask

    task automatic t_granule();
        xfer(0, 1, 3, 'h0200, 2);
        xfer(1, 1, 3, 'h0207, 2); expect_rsp("R6 same granule matches", EXO, 1);
        xfer(0, 1, 3, 'h0200, 2);
        xfer(1, 1, 3, 'h0200, 3); expect_rsp("R6 size mismatch", OK, 0);
        xfer(0, 1, 3, 'h0300, 2);
        xfer(1, 1, 3, 'h0308, 2); expect_rsp("R6 next granule mismatch", OK, 0);
    endtask

    task automatic t_overwrite();
        xfer(0, 1, 4, 'h0400, 2);
        xfer(0, 1, 4, 'h0500, 2);
        xfer(1, 1, 4, 'h0400, 2); expect_rsp("R2 replaced reservation", OK, 0);
        xfer(1, 1, 4, 'h0500, 2); expect_rsp("R2 new reservation", EXO, 1);
    endtask

    task automatic t_all_ids();
        for (int i = 0; i < (1 << ID_W); i++) xfer(0, 1, i, 'h1000 + i * 'h40, 1);
        for (int i = 0; i < (1 << ID_W); i++) begin
            xfer(1, 1, i, 'h1000 + i * 'h40, 1);
            expect_rsp($sformatf("R2 all ids id%0d", i), EXO, 1);
        end
    endtask

    task automatic t_plain_read();
        xfer(0, 1, 6, 'h0600, 2);
        xfer(0, 0, 6, 'h0600, 2); expect_rsp("R7 plain read", OK, 0);
        xfer(1, 1, 6, 'h0600, 2); expect_rsp("R7 table unchanged", EXO, 1);
    endtask

    task automatic t_failed_keeps();
        xfer(0, 1, 1, 'h0700, 2);
        xfer(1, 1, 0, 'h0700, 2); expect_rsp("R5 no entry fails", OK, 0);
        xfer(1, 1, 1, 'h0700, 2); expect_rsp("R5 failed write kept table", EXO, 1);
    endtask

    task automatic t_unsupported();
        xfer(0, 1, 2, 'h0900, 2);
        check("R9 excl read unsupported", {nx_resp_valid, nx_resp_code}, {1'b1, OK});
        xfer(1, 1, 2, 'h0900, 2);
        check("R9 excl write unsupported", {nx_resp_wr_ok, nx_resp_code}, {1'b0, OK});
        xfer(1, 0, 2, 'h0900, 2);
        check("R9 plain write commits", {nx_resp_wr_ok, nx_resp_code}, {1'b1, OK});
    endtask

    task automatic t_stall();
        idle();
        resp_ready = 1'b0;
        xfer(0, 1, 0, 'h0800, 2);
        expect_rsp("R10 stalled response", EXO, 0);
        check("R10 ready low in stall", {2'b0, req_ready}, 3'b000);
        req_valid = 1'b1; req_write = 1'b1; req_excl = 1'b1;
        req_id = '0; req_addr = 'h0800; req_size = 3'd2;
        @(negedge clk);
        expect_rsp("R10 response held", EXO, 0);
        resp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R10 accepted after release", EXO, 1);
        idle();
        check("R10 response drained", {2'b0, resp_valid}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_both_pass();
        t_one_fails();
        t_plain_write_breaks();
        t_granule();
        t_overwrite();
        t_all_ids();
        t_plain_read();
        t_failed_keeps();
        t_unsupported();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule